// File: doc/BRIEF.md
# Data-Cache Directory Statistics Engine

This block models the bookkeeping side of a small data cache without holding any data. It keeps only tags, valid bits, dirty bits and one replacement bit per set. A stream of memory references is fed in, one per cycle. For each reference the engine decides whether it hits, picks a way to fill on a miss, and updates four running counters: total references, hits, cold-start misses and dirty-block write-backs.

The modelled cache holds 256 bytes. It is 2-way set-associative with 8-byte blocks, uses a write-back, write-allocate policy and evicts the least recently used way. A producer pushes (operation, byte address) pairs over a valid/ready handshake. A terminating operation freezes the counters and raises a done flag. The counters stay readable until the next reset. A performance-analysis harness can therefore replay an address trace and read cache statistics without running any software model.

Top module: `tagstat_engine`

## Requirements
- R1: An address is split into byte offset bits [2:0], set index bits [6:3] and tag bits [31:7]. This gives 16 sets of 2 ways. Two addresses that differ only in offset bits hit the same block. Addresses that differ in an index bit land in different sets.
- R2: Operation code 1 (read) and code 2 (write) are references. Each accepted reference raises the reference counter by exactly one, visible on the counter outputs after the accepting clock edge. The counters are 16 bits wide by default and count well past 1024 references.
- R3: A reference whose tag matches a valid way of its set is a hit and raises the hit counter by one.
- R4: A miss in a set that still has an invalid way fills that way and raises the cold-miss counter by one. It never evicts a valid way.
- R5: A miss in a full set evicts the least recently used way. Every hit or fill marks the accessed way as most recently used.
- R6: A write, hit or miss, leaves its line dirty. A line filled by a read starts clean. A read hit leaves the dirty state unchanged.
- R7: Evicting a dirty victim raises the write-back counter by one. Evicting a clean victim leaves it unchanged.
- R8: Operation code 0 ends the trace; its address is not examined. It is not counted. done is high from the next cycle, in_ready goes low, and any later input leaves the counters unchanged until reset.
- R9: Operation code 3 is reserved. It is accepted but changes neither the counters nor the directory: a later read of the same address is a cold miss.
- R10: An active-low reset clears all counters, done and every valid, dirty and replacement bit. A reference after reset to a block seen before the reset is a cold miss.
- R11: While done is low and reset is complete, in_ready is high and one reference is accepted in every cycle. A reference sees the directory update made by the reference in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A reference is offered this cycle |
| in_ready | output | 1 | The engine accepts a reference this cycle |
| in_op | input | 2 | Operation: 0 end of trace, 1 read, 2 write, 3 reserved |
| in_addr | input | 32 | Byte address of the reference |
| done | output | 1 | End of trace seen; counters frozen |
| cnt_refs | output | 16 | Accepted read and write references |
| cnt_hits | output | 16 | References that hit |
| cnt_cold | output | 16 | Misses that filled an invalid way |
| cnt_wb | output | 16 | Dirty victims evicted |

## Verification
The assertions assume the counters never wrap. Hits and cold misses can then never sum past the reference count, and no counter steps by more than one per cycle. The stimulus stays well below 65536 references between resets, with its longest burst at 1100. The assertions also assume that a set never holds the same tag in both ways. Only the engine fills ways, and it fills only on a miss, so the stimulus keeps this by offering addresses only through the handshake and never by forcing directory state. Inputs change only on the falling edge, so each accepted reference is stable across its rising edge.

// File: rtl/tagstat_pkg.sv
package tagstat_pkg;

  // Operation encoding on in_op
  typedef enum logic [1:0] {
    OP_END   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } tagstat_op_e;

  // Slots of the statistics counter bank
  localparam int unsigned ST_REFS = 0;
  localparam int unsigned ST_HITS = 1;
  localparam int unsigned ST_COLD = 2;
  localparam int unsigned ST_WB   = 3;
  localparam int unsigned ST_NUM  = 4;

  // Per-reference verdict from the directory
  typedef struct packed {
    logic hit;
    logic cold;
    logic wb;
  } tagstat_verdict_t;

endpackage

// File: rtl/tagstat_split.sv
module tagstat_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  // Offset bits select a byte within a block and play no part in lookup.
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/tagstat_ctr.sv
module tagstat_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] count_q;
  logic [W-1:0] count_nx;

  always_comb begin
    count_nx = count_q;
    if (inc) count_nx = count_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (inc) count_q <= count_nx;
  end

  assign count = count_q;

  // R2: a counter moves by at most one step per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == $past(count_q)) || (count_q == $past(count_q) + W'(1)));

endmodule

// File: rtl/tagstat_dir.sv
module tagstat_dir
  import tagstat_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 25,
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAYS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [TAG_W-1:0] acc_tag,
  output tagstat_verdict_t verdict
);

  // Directory state: per set, per way
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic             lru_q   [SETS];   // way to evict next
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  // Lookup of the addressed set
  logic [WAYS-1:0] set_valid;
  logic [WAYS-1:0] set_dirty;
  logic [WAYS-1:0] hit_vec;
  logic            any_hit;
  logic            has_free;
  logic            free_way;
  logic            victim;
  logic            use_way;

  // Next state of the addressed set
  logic [WAYS-1:0] valid_nx;
  logic [WAYS-1:0] dirty_nx;
  logic            lru_nx;

  assign set_valid = valid_q[acc_idx];
  assign set_dirty = dirty_q[acc_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_valid[w] && (tag_q[acc_idx][w] == acc_tag);
  end

  always_comb begin
    any_hit  = |hit_vec;
    has_free = ~&set_valid;
    // lowest invalid way first
    free_way = set_valid[0];
    victim   = has_free ? free_way : lru_q[acc_idx];
    use_way  = any_hit ? hit_vec[1] : victim;

    verdict.hit  = any_hit;
    verdict.cold = !any_hit && has_free;
    verdict.wb   = !any_hit && !has_free && set_dirty[victim];
  end

  always_comb begin
    valid_nx          = set_valid;
    dirty_nx          = set_dirty;
    valid_nx[use_way] = 1'b1;
    if (any_hit) dirty_nx[use_way] = set_dirty[use_way] | acc_wr;
    else         dirty_nx[use_way] = acc_wr;
    lru_nx            = ~use_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SETS); s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        lru_q[s]   <= 1'b0;
      end
    end else if (acc_en) begin
      valid_q[acc_idx] <= valid_nx;
      dirty_q[acc_idx] <= dirty_nx;
      lru_q[acc_idx]   <= lru_nx;
    end
  end

  // Tag storage needs no reset: a tag is read only behind its valid bit.
  always_ff @(posedge clk) begin
    if (acc_en && !any_hit) tag_q[acc_idx][use_way] <= acc_tag;
  end

  // R3: a set never matches one tag in both ways
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> $onehot0(hit_vec));

  // R4: a valid way that was hit stays valid after the access
  a_r4_hit_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && any_hit) |=> (valid_q[$past(acc_idx)] == $past(set_valid)));

endmodule

// File: rtl/tagstat_engine.sv
module tagstat_engine
  import tagstat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BLK_BYTES = 8,
  parameter int unsigned SETS      = 16,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned OFF_W    = $clog2(BLK_BYTES),
  localparam int unsigned IDX_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned TAG_W    = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              done,
  output logic [CNT_W-1:0]  cnt_refs,
  output logic [CNT_W-1:0]  cnt_hits,
  output logic [CNT_W-1:0]  cnt_cold,
  output logic [CNT_W-1:0]  cnt_wb
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Handshake and operation decode
  tagstat_op_e op;
  logic        accept;
  logic        is_ref;
  logic        is_end;
  logic        done_q;
  logic        done_nx;

  assign op       = tagstat_op_e'(in_op);
  assign in_ready = rst_sync_n && !done_q;
  assign accept   = in_valid && in_ready;
  assign is_ref   = accept && ((op == OP_READ) || (op == OP_WRITE));
  assign is_end   = accept && (op == OP_END);

  always_comb begin
    done_nx = done_q;
    if (is_end) done_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else if (is_end) done_q <= done_nx;
  end

  assign done = done_q;

  // Address split and directory
  logic [IDX_W-1:0] ref_idx;
  logic [TAG_W-1:0] ref_tag;
  tagstat_verdict_t verdict;

  tagstat_split #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_split (
    .addr(in_addr),
    .idx (ref_idx),
    .tag (ref_tag)
  );

  tagstat_dir #(
    .SETS (SETS),
    .TAG_W(TAG_W)
  ) u_dir (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .acc_en (is_ref),
    .acc_wr (op == OP_WRITE),
    .acc_idx(ref_idx),
    .acc_tag(ref_tag),
    .verdict(verdict)
  );

  // Statistics counter bank
  logic [ST_NUM-1:0] stat_inc;
  logic [CNT_W-1:0]  stat_cnt [ST_NUM];

  always_comb begin
    stat_inc          = '0;
    stat_inc[ST_REFS] = is_ref;
    stat_inc[ST_HITS] = is_ref && verdict.hit;
    stat_inc[ST_COLD] = is_ref && verdict.cold;
    stat_inc[ST_WB]   = is_ref && verdict.wb;
  end

  for (genvar k = 0; k < int'(ST_NUM); k++) begin : g_stat
    tagstat_ctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .inc  (stat_inc[k]),
      .count(stat_cnt[k])
    );
  end

  assign cnt_refs = stat_cnt[ST_REFS];
  assign cnt_hits = stat_cnt[ST_HITS];
  assign cnt_cold = stat_cnt[ST_COLD];
  assign cnt_wb   = stat_cnt[ST_WB];

  // R8: once done, counters hold still
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> ($stable(cnt_refs) && $stable(cnt_hits) && $stable(cnt_cold) && $stable(cnt_wb)));

  // R8: done never drops without reset
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> done_q);

  // R3 / R4: hits and cold misses are disjoint subsets of references
  a_r3_partition: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ({1'b0, cnt_hits} + {1'b0, cnt_cold}) <= {1'b0, cnt_refs});

  // R7: a write-back only happens together with a counted reference
  a_r7_wb_with_ref: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_wb != $past(cnt_wb)) |-> (cnt_refs != $past(cnt_refs)));

  // R9: a reserved operation leaves the reference count alone
  a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && (op == OP_RSVD)) |=> $stable(cnt_refs));

  // R11: a reference is never dropped while the engine is ready
  a_r11_ready_counts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_ref |=> (cnt_refs == $past(cnt_refs) + CNT_W'(1)));

endmodule

// File: tb/test_tagstat_engine.sv
module test_tagstat_engine;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = 2'd0;
  logic [31:0]   in_addr = 32'd0;
  logic          in_ready;
  logic          done;
  logic [CW-1:0] cnt_refs, cnt_hits, cnt_cold, cnt_wb;

  // 250 MHz: 4-unit period
  always #2 clk = ~clk;

  tagstat_engine i_tagstat_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_op   (in_op),
    .in_addr (in_addr),
    .done    (done),
    .cnt_refs(cnt_refs),
    .cnt_hits(cnt_hits),
    .cnt_cold(cnt_cold),
    .cnt_wb  (cnt_wb)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [CW-1:0] b_r, b_h, b_c, b_w;

  function automatic logic [31:0] mk(int tag, int set, int off);
    return (32'(tag) << 7) | (32'(set) << 3) | 32'(off);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic snap();
    b_r = cnt_refs; b_h = cnt_hits; b_c = cnt_cold; b_w = cnt_wb;
  endtask

  task automatic delta(string req, int dr, int dh, int dc, int dw);
    chk(req, "refs delta", longint'(cnt_refs) - longint'(b_r), dr);
    chk(req, "hits delta", longint'(cnt_hits) - longint'(b_h), dh);
    chk(req, "cold delta", longint'(cnt_cold) - longint'(b_c), dc);
    chk(req, "wb delta",   longint'(cnt_wb)   - longint'(b_w), dw);
  endtask

  // one reference, one idle cycle after it
  task automatic send(logic [1:0] op, logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "refs", cnt_refs, 0);
    chk("R10", "hits", cnt_hits, 0);
    chk("R10", "cold", cnt_cold, 0);
    chk("R10", "wb",   cnt_wb,   0);
    chk("R10", "done", done, 0);
    chk("R11", "ready", in_ready, 1);
  endtask

  task automatic t_split();
    snap();
    send(2'd1, mk(1, 0, 0));
    delta("R2", 1, 0, 1, 0);             // first reference is a cold fill
    send(2'd1, mk(1, 0, 4));
    delta("R1", 2, 1, 1, 0);             // offset change hits same block
    send(2'd1, mk(1, 1, 0));
    delta("R1", 3, 1, 2, 0);             // index bit change is a new set
    send(2'd2, mk(1, 0, 7));
    delta("R3", 4, 2, 2, 0);             // write hit
  endtask

  task automatic t_lru();
    snap();
    send(2'd1, mk(10, 2, 0));            // A cold
    send(2'd1, mk(11, 2, 0));            // B cold, no eviction of A
    send(2'd1, mk(10, 2, 0));            // A hit
    delta("R4", 3, 1, 2, 0);
    send(2'd1, mk(12, 2, 0));            // C evicts B
    send(2'd1, mk(10, 2, 0));            // A still present
    delta("R5", 5, 2, 2, 0);
    send(2'd1, mk(11, 2, 0));            // B evicts C
    send(2'd1, mk(12, 2, 0));            // C evicts A
    send(2'd1, mk(11, 2, 0));            // B hit
    delta("R5", 8, 3, 2, 0);
  endtask

  task automatic t_writeback();
    snap();
    send(2'd2, mk(20, 3, 0));            // X write cold, dirty
    send(2'd1, mk(21, 3, 0));            // Y cold clean
    send(2'd1, mk(22, 3, 0));            // Z evicts dirty X
    delta("R7", 3, 0, 2, 1);
    send(2'd1, mk(23, 3, 0));            // W evicts clean Y
    delta("R7", 4, 0, 2, 1);
    send(2'd2, mk(22, 3, 0));            // write hit makes Z dirty
    send(2'd1, mk(24, 3, 0));            // V evicts clean W
    send(2'd1, mk(25, 3, 0));            // U evicts dirty Z
    delta("R6", 7, 1, 2, 2);
    snap();
    send(2'd2, mk(30, 4, 0));            // P dirty
    send(2'd1, mk(31, 4, 0));            // Q clean
    send(2'd1, mk(32, 4, 0));            // R evicts P (dirty), read fill
    send(2'd1, mk(33, 4, 0));            // S evicts Q (clean)
    send(2'd1, mk(34, 4, 0));            // evicts read-filled R: clean
    delta("R6", 5, 0, 2, 1);
  endtask

  task automatic t_reserved();
    snap();
    send(2'd3, mk(40, 5, 0));
    delta("R9", 0, 0, 0, 0);
    chk("R9", "done", done, 0);
    send(2'd1, mk(40, 5, 0));
    delta("R9", 1, 0, 1, 0);             // directory was untouched
  endtask

  task automatic t_burst();
    snap();
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'd1; in_addr = mk(50, 6, 0);
    @(negedge clk);
    chk("R11", "ready mid-burst", in_ready, 1);
    in_addr = mk(50, 6, 2);
    @(negedge clk);
    in_valid = 1'b0;
    delta("R11", 2, 1, 1, 0);            // second sees first's fill
  endtask

  task automatic t_end();
    snap();
    send(2'd0, 32'd0);
    chk("R8", "done", done, 1);
    chk("R8", "ready", in_ready, 0);
    delta("R8", 0, 0, 0, 0);
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'd1; in_addr = mk(60, 7, 0);
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    delta("R8", 0, 0, 0, 0);
    chk("R8", "done held", done, 1);
    do_reset();
    t_reset();
    snap();
    send(2'd1, mk(1, 0, 0));             // seen before reset, now cold
    delta("R10", 1, 0, 1, 0);
  endtask

  task automatic t_volume();
    snap();
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'd1; in_addr = mk(70, 9, 0);
    repeat (1100) @(negedge clk);
    in_valid = 1'b0;
    delta("R2", 1100, 1099, 1, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_split();
    t_lru();
    t_writeback();
    t_reserved();
    t_burst();
    t_end();
    t_volume();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule